// File: doc/BRIEF.md
# Interrupt-Acknowledge Chip-Select Decoder

This block watches the processor bus and decides, cycle by cycle, whether a chip-select output should fire and how the cycle should end. It compares the upper address bits with a programmable base value and masks out the low bits that fall inside the selected block size. It qualifies the match by function code, read/write direction and, in CPU space, by the interrupt-acknowledge type code and the priority level on the low address bits.

Termination is either an autovector strobe or a data-size acknowledge, raised after a programmable number of wait cycles. Byte-lane enables follow the selected port lanes. A 16-bit port that supplies a vector uses the low lane, and an 8-bit port uses the high lane. If an on-chip module owns the level being acknowledged, the decoder stays silent and the module supplies the vector itself. The base and option words are static configuration inputs held by the surrounding logic.

Top module: `iack_cs_decoder`

## Requirements
- R1: While rst_ni is low, and at the first clock after it rises, cs_o, avec_o, dsack_o and byte_en_o are all zero.
- R2: With fc_i = 3'b111 (CPU space), cs_o asserts only when addr_i[19:16] = 4'b1111 (interrupt acknowledge). Any other type code in CPU space gives no response.
- R3: base_i[15:3] is compared with addr_i[23:11]. base_i[2:0] selects the block size: 000 2K, 001 8K, 010 16K, 011 64K, 100 128K, 101 256K, 110 512K, 111 1M. Address bits inside the block are ignored, so sizes of 64K or less include addr_i[19:16] in the compare.
- R4: In an interrupt acknowledge, opt_i[11:9] must equal addr_i[3:1]. When opt_i[12] = 1, any level matches.
- R5: When int_owned_i is high during an interrupt acknowledge, cs_o, avec_o and dsack_o stay low even when the level matches.
- R6: opt_i[3:2] qualifies direction (rw_i = 1 means read). 01 allows reads only, 10 writes only, 11 both, and 00 neither.
- R7: byte_en_o equals opt_i[1:0] ({high lane, low lane}) while cs_o is high, and is zero otherwise.
- R8: opt_i[4] = 1 ends the cycle with avec_o, and opt_i[4] = 0 ends it with dsack_o. The two never assert together, and neither asserts without cs_o.
- R9: opt_i[8:5] gives the wait count W, and values above 13 act as 13. cs_o rises one clock after as_i is sampled high on a matching cycle. The termination output rises W clocks after cs_o.
- R10: opt_i[15:13] gives the function code that must match fc_i. All outputs are low one clock after as_i is sampled low, and stay low while as_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address |
| fc_i | input | 3 | Function code |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_i | input | 1 | Address strobe, active high |
| int_owned_i | input | 1 | On-chip module owns the pending level |
| base_i | input | 16 | Base address [15:3] and block size [2:0] |
| opt_i | input | 16 | Option word (fields per R4, R6 to R10) |
| cs_o | output | 1 | Chip select |
| avec_o | output | 1 | Autovector termination |
| dsack_o | output | 1 | Data-size acknowledge termination |
| byte_en_o | output | 2 | Byte-lane enables {high, low} |

## Verification
The wait-state expiry and the strobe release can land on the same clock. With a wait count of 3, the bench holds the strobe for exactly three clocks, so the edge where the acknowledge would rise is the edge where the strobe is already sampled low. The scoreboard expects chip-select to fall on that edge and the termination outputs to stay low throughout. A second collision places an owned interrupt level on a cycle whose level and address otherwise match. The release rule and the suppression rule must each win without a one-clock glitch on any output.

// File: rtl/iack_cs_pkg.sv
package iack_cs_pkg;
  localparam int ADDR_W  = 24;
  localparam int FC_W    = 3;
  localparam int CMP_LSB = 11;
  localparam int CMP_W   = ADDR_W - CMP_LSB;
  localparam int CNT_W   = 4;

  localparam logic [FC_W-1:0] FC_CPU    = 3'b111;
  localparam logic [3:0]      TYPE_IACK = 4'hF;

  typedef struct packed {
    logic [FC_W-1:0]  fc_sel;
    logic             any_lvl;
    logic [2:0]       lvl;
    logic [CNT_W-1:0] wait_n;
    logic             use_avec;
    logic [1:0]       rw_sel;
    logic [1:0]       lanes;
  } opt_t;

  function automatic logic [CMP_W-1:0] size_mask(input logic [2:0] sz);
    logic [CMP_W-1:0] m;
    int drop;
    case (sz)
      3'd0:    drop = 0;
      3'd1:    drop = 2;
      3'd2:    drop = 3;
      3'd3:    drop = 5;
      3'd4:    drop = 6;
      3'd5:    drop = 7;
      3'd6:    drop = 8;
      default: drop = 9;
    endcase
    m = '1;
    m = m << drop;
    return m;
  endfunction
endpackage

// File: rtl/cs_addr_cmp.sv
module cs_addr_cmp
  import iack_cs_pkg::*;
(
  input  logic [CMP_W-1:0] addr_hi_i,
  input  logic [CMP_W-1:0] base_hi_i,
  input  logic [2:0]       size_i,
  output logic             hit_o
);
  logic [CMP_W-1:0] diff;
  assign diff  = (addr_hi_i ^ base_hi_i) & size_mask(size_i);
  assign hit_o = (diff == '0);
endmodule

// File: rtl/cs_cycle_qual.sv
module cs_cycle_qual
  import iack_cs_pkg::*;
(
  input  logic            as_i,
  input  logic [FC_W-1:0] fc_i,
  input  logic            rw_i,
  input  logic [3:0]      type_i,
  input  logic [2:0]      lvl_i,
  input  logic            int_owned_i,
  input  opt_t            opt_i,
  output logic            ok_o
);
  logic fc_ok, cpu, iack, lvl_ok, rw_ok;

  assign fc_ok  = (fc_i == opt_i.fc_sel);
  assign cpu    = (fc_i == FC_CPU);
  assign iack   = (type_i == TYPE_IACK);
  assign lvl_ok = opt_i.any_lvl || (opt_i.lvl == lvl_i);

  always_comb begin
    unique case (opt_i.rw_sel)
      2'b01:   rw_ok = rw_i;
      2'b10:   rw_ok = !rw_i;
      2'b11:   rw_ok = 1'b1;
      default: rw_ok = 1'b0;
    endcase
  end

  // CPU space responds only to an acknowledge at a level nobody on-chip owns
  assign ok_o = as_i && fc_ok && rw_ok &&
                (!cpu || (iack && lvl_ok && !int_owned_i));
endmodule

// File: rtl/cs_term_timer.sv
module cs_term_timer #(
  parameter int CNT_W    = 4,
  parameter int MAX_WAIT = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] wait_i,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] CLAMP = CNT_W'(MAX_WAIT);
  localparam logic [CNT_W-1:0] SAT   = '1;

  logic [CNT_W-1:0] cnt_q, eff;

  assign eff     = (wait_i > CLAMP) ? CLAMP : wait_i;
  assign ready_o = (cnt_q >= eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!hit_i)     cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/iack_cs_decoder.sv
module iack_cs_decoder
  import iack_cs_pkg::*;
#(
  parameter int MAX_WAIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic              rw_i,
  input  logic              as_i,
  input  logic              int_owned_i,
  input  logic [15:0]       base_i,
  input  logic [15:0]       opt_i,
  output logic              cs_o,
  output logic              avec_o,
  output logic              dsack_o,
  output logic [1:0]        byte_en_o
);
  opt_t opt;
  logic addr_hit, qual_ok, hit, ready;

  assign opt = opt_t'(opt_i);

  cs_addr_cmp u_cmp (
    .addr_hi_i (addr_i[ADDR_W-1:CMP_LSB]),
    .base_hi_i (base_i[15:3]),
    .size_i    (base_i[2:0]),
    .hit_o     (addr_hit)
  );

  cs_cycle_qual u_qual (
    .as_i        (as_i),
    .fc_i        (fc_i),
    .rw_i        (rw_i),
    .type_i      (addr_i[19:16]),
    .lvl_i       (addr_i[3:1]),
    .int_owned_i (int_owned_i),
    .opt_i       (opt),
    .ok_o        (qual_ok)
  );

  assign hit = addr_hit && qual_ok;

  cs_term_timer #(.CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .wait_i  (opt.wait_n),
    .ready_o (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o      <= 1'b0;
      avec_o    <= 1'b0;
      dsack_o   <= 1'b0;
      byte_en_o <= '0;
    end else begin
      cs_o      <= hit;
      avec_o    <= hit && ready && opt.use_avec;
      dsack_o   <= hit && ready && !opt.use_avec;
      byte_en_o <= hit ? opt.lanes : 2'b00;
    end
  end
endmodule

// File: rtl/iack_cs_decoder_chk.sv
module iack_cs_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [23:0] addr_i,
  input logic [2:0]  fc_i,
  input logic        rw_i,
  input logic        as_i,
  input logic        int_owned_i,
  input logic [15:0] opt_i,
  input logic        cs_o,
  input logic        avec_o,
  input logic        dsack_o,
  input logic [1:0]  byte_en_o
);
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> (!cs_o && !avec_o && !dsack_o && byte_en_o == 2'b00));

  a_r8_single_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(avec_o && dsack_o));

  a_r8_term_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avec_o || dsack_o) |-> cs_o);

  a_r5_owned_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && fc_i == 3'b111 && addr_i[19:16] == 4'hF && int_owned_i)
      |=> (!cs_o && !avec_o && !dsack_o));

  a_r7_lanes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> (byte_en_o == 2'b00));

  a_r6_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && opt_i[3:2] == 2'b01 && !rw_i) |=> !cs_o);

  a_r2_cpu_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && fc_i == 3'b111 && addr_i[19:16] != 4'hF) |=> !cs_o);
endmodule

bind iack_cs_decoder iack_cs_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .fc_i        (fc_i),
  .rw_i        (rw_i),
  .as_i        (as_i),
  .int_owned_i (int_owned_i),
  .opt_i       (opt_i),
  .cs_o        (cs_o),
  .avec_o      (avec_o),
  .dsack_o     (dsack_o),
  .byte_en_o   (byte_en_o)
);

// File: tb/iack_cs_decoder_tb.sv
module iack_cs_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        rw = 1'b1;
  logic        as_s = 1'b0;
  logic        own = 1'b0;
  logic [15:0] base = '0;
  logic [15:0] opt = '0;
  logic        cs, avec, dsack;
  logic [1:0]  be;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic cs, avec, dsack;
    logic [1:0] be;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  iack_cs_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .fc_i(fc), .rw_i(rw),
    .as_i(as_s), .int_owned_i(own), .base_i(base), .opt_i(opt),
    .cs_o(cs), .avec_o(avec), .dsack_o(dsack), .byte_en_o(be)
  );

  function automatic logic [15:0] mk_opt(input logic [2:0] f, input logic any,
      input logic [2:0] l, input logic [3:0] w, input logic av,
      input logic [1:0] rws, input logic [1:0] ln);
    return {f, any, l, w, av, rws, ln};
  endfunction

  function automatic logic [23:0] iack_addr(input logic [2:0] l);
    return (24'hFFFFFF & ~24'h00000E) | {20'h0, l, 1'b0};
  endfunction

  // Bench model of the matching rules
  function automatic logic model_hit(input logic [23:0] a, input logic [2:0] f,
      input logic r, input logic o);
    int ign;
    logic ok;
    case (base[2:0])
      3'd0: ign = 11; 3'd1: ign = 13; 3'd2: ign = 14; 3'd3: ign = 16;
      3'd4: ign = 17; 3'd5: ign = 18; 3'd6: ign = 19; default: ign = 20;
    endcase
    ok = 1'b1;
    for (int b = ign; b < 24; b++)
      if (a[b] != base[b - 8]) ok = 1'b0;
    if (f != opt[15:13]) ok = 1'b0;
    if (opt[3:2] == 2'b00) ok = 1'b0;
    if (opt[3:2] == 2'b01 && !r) ok = 1'b0;
    if (opt[3:2] == 2'b10 && r) ok = 1'b0;
    if (f == 3'b111) begin
      if (a[19:16] != 4'hF) ok = 1'b0;
      if (!opt[12] && opt[11:9] != a[3:1]) ok = 1'b0;
      if (o) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic push(input exp_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic bus_cycle(input logic [23:0] a, input logic [2:0] f,
      input logic r, input logic o, input int n_as, input string t);
    logic h;
    int   w;
    exp_t e;
    w = (opt[8:5] > 4'd13) ? 13 : int'(opt[8:5]);
    h = model_hit(a, f, r, o);
    for (int k = 1; k <= n_as; k++) begin
      @(negedge clk);
      addr = a; fc = f; rw = r; own = o; as_s = 1'b1;
      e.cs    = h;
      e.avec  = h && (k - 1 >= w) && opt[4];
      e.dsack = h && (k - 1 >= w) && !opt[4];
      e.be    = h ? opt[1:0] : 2'b00;
      push(e, t);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      as_s = 1'b0;
      push('0, t);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #5;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({cs, avec, dsack, be} !== e) begin
          n_bad++;
          $display("FAIL %s: got cs=%b avec=%b dsack=%b be=%b exp cs=%b avec=%b dsack=%b be=%b",
                   t, cs, avec, dsack, be, e.cs, e.avec, e.dsack, e.be);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hung exp done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    n_chk++;
    if ({cs, avec, dsack, be} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: got %b exp 00000", {cs, avec, dsack, be});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R7 R8 R9: level 5 acknowledge, dsack, no wait, low lane
    base = 16'hFFFF;
    opt  = mk_opt(3'b111, 1'b0, 3'd5, 4'd0, 1'b0, 2'b01, 2'b01);
    bus_cycle(iack_addr(3'd5), 3'b111, 1'b1, 1'b0, 3, "R2_iack_hit");
    // R4: level mismatch, then any-level
    bus_cycle(iack_addr(3'd3), 3'b111, 1'b1, 1'b0, 3, "R4_lvl_miss");
    opt[12] = 1'b1;
    bus_cycle(iack_addr(3'd3), 3'b111, 1'b1, 1'b0, 3, "R4_any_lvl");
    opt[12] = 1'b0;
    // R5: owned level
    bus_cycle(iack_addr(3'd5), 3'b111, 1'b1, 1'b1, 3, "R5_owned");
    // R2: CPU space, non-acknowledge type, 1M block hides type bits from compare
    base = 16'hFFFF;
    bus_cycle(iack_addr(3'd5) & 24'hF0FFFF, 3'b111, 1'b1, 1'b0, 3, "R2_other_type");
    // R10: function code mismatch
    bus_cycle(iack_addr(3'd5), 3'b101, 1'b1, 1'b0, 3, "R10_fc_miss");
    // R6: write rejected on read-only
    bus_cycle(iack_addr(3'd5), 3'b111, 1'b0, 1'b0, 3, "R6_wr_ro");

    // R3: program space, 64K block
    opt  = mk_opt(3'b101, 1'b0, 3'd0, 4'd1, 1'b0, 2'b11, 2'b11);
    base = {13'h0ABC, 3'b011};
    bus_cycle({13'h0ABC, 11'h123}, 3'b101, 1'b1, 1'b0, 4, "R3_64k_hit");
    bus_cycle({13'h0ABC ^ 13'h0020, 11'h123}, 3'b101, 1'b1, 1'b0, 4, "R3_64k_bit16");
    base = {13'h0ABC, 3'b111};
    bus_cycle({13'h0ABC ^ 13'h0020, 11'h123}, 3'b101, 1'b0, 1'b0, 4, "R3_1m_ignore");
    bus_cycle({13'h0ABC ^ 13'h0200, 11'h123}, 3'b101, 1'b1, 1'b0, 4, "R3_1m_bit20");
    base = {13'h0ABC, 3'b000};
    bus_cycle({13'h0ABC ^ 13'h0001, 11'h123}, 3'b101, 1'b1, 1'b0, 3, "R3_2k_bit11");

    // R6: direction modes
    opt[3:2] = 2'b10;
    bus_cycle({13'h0ABC, 11'h0}, 3'b101, 1'b0, 1'b0, 3, "R6_wo_write");
    bus_cycle({13'h0ABC, 11'h0}, 3'b101, 1'b1, 1'b0, 3, "R6_wo_read");
    opt[3:2] = 2'b00;
    bus_cycle({13'h0ABC, 11'h0}, 3'b101, 1'b1, 1'b0, 3, "R6_never");

    // R8 R7: autovector, upper lane, wait 2
    base = 16'hFFFF;
    opt  = mk_opt(3'b111, 1'b0, 3'd7, 4'd2, 1'b1, 2'b01, 2'b10);
    bus_cycle(iack_addr(3'd7), 3'b111, 1'b1, 1'b0, 5, "R8_avec");
    // R9: wait 13 and clamped 15
    opt[8:5] = 4'd13; opt[4] = 1'b0;
    bus_cycle(iack_addr(3'd7), 3'b111, 1'b1, 1'b0, 16, "R9_wait13");
    opt[8:5] = 4'd15;
    bus_cycle(iack_addr(3'd7), 3'b111, 1'b1, 1'b0, 16, "R9_clamp");
    // R10: strobe drops on the edge the acknowledge would rise
    opt[8:5] = 4'd3;
    bus_cycle(iack_addr(3'd7), 3'b111, 1'b1, 1'b0, 3, "R10_short_as");
    bus_cycle(iack_addr(3'd7), 3'b111, 1'b1, 1'b0, 4, "R9_wait3");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule